// File: doc/BRIEF.md
# Algorithm-Level Self-Checking Block Cipher

This block runs an iterative 128-bit substitution-permutation cipher and checks every result before releasing it. After a start request it captures the plaintext and keeps a copy. It encrypts the block over 32 rounds. It then sends the ciphertext back through the full inverse cipher and compares the recovered word with the saved copy. The encryption and decryption datapaths share one state register, one key-memory read port and one output port, because only one direction is ever active.

If the recovered word equals the saved plaintext, the ciphertext is released. If they differ, the block assumes a fault, for example one induced by radiation to extract the key. It then releases a word from a free-running pseudo-random generator in place of the ciphertext and raises a sticky error flag. A fault-injection mask input lets a bench corrupt the encryption state on purpose.

Round keys are preloaded into an external memory of 33 words, read combinationally through `key_addr` and `key_rdata`. No key schedule is computed here.

Top module: `ced_cipher_guard`

## Requirements
- R1: While reset is asserted and after it is released, `valid`, `error` and `cipher_out` read zero until the first result is released.
- R2: A `start` seen while idle captures `plaintext`. While a computation is running, `start` and any change on `plaintext` have no effect on the result.
- R3: Encryption round r (0 to 31) XORs key word r into the state. It then replaces each 4-bit nibble n through the table C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (index 0 to 15). Rounds 0 to 30 then apply the mixing layer. Take lanes a=[31:0], b=[63:32], c=[95:64], d=[127:96] and compute, in order, a^=rotl(d,5), b^=rotl(a,11), c^=rotl(b,7), d^=rotl(c,3). Round 31 XORs key word 32 instead of mixing.
- R4: Each round takes 2 cycles. `valid` is a single-cycle pulse visible 128 cycles after the clock edge that accepts `start` (64 encrypting, 64 decrypting).
- R5: When the decrypted word equals the held plaintext, `cipher_out` carries the ciphertext and `error` is 0 with the `valid` pulse.
- R6: On a mismatch, `cipher_out` carries the value of a 128-bit LFSR and `error` is 1. The LFSR is seeded with 128'h0123456789ABCDEF_FEDCBA9876543210 at reset and shifts left every cycle, taking in bit127^bit125^bit100^bit98. The released word is its value just before the releasing edge.
- R7: `error` and `cipher_out` hold after a release until the next accepted `start`. That start clears `error` in the next cycle.
- R8: A nonzero `inject_flip` is XORed into the state on each encryption cycle, so any such flip yields an error. During decryption or while idle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a checked encryption when idle |
| plaintext | input | 128 | Block to encrypt, sampled at accepted start |
| inject_flip | input | 128 | Fault mask XORed into the encryption state |
| key_addr | output | 6 | Round-key memory read address |
| key_rdata | input | 128 | Round-key word at `key_addr`, same cycle |
| cipher_out | output | 128 | Released ciphertext or substitute word |
| valid | output | 1 | One-cycle pulse marking a release |
| error | output | 1 | Sticky mismatch flag |

## Verification
The bench models the cipher, the LFSR and the cycle count itself, and compares all outputs every clock. It aims faults at the first and last encryption cycles; a design that misplaced the phase boundary would miss one of them, or flag a fault injected during decryption. It raises `start` with a new plaintext mid-run, which catches a design that re-arms or re-samples. It also checks that the flag survives idle cycles, that the next start clears it, and that latency is exactly 128, which exposes an extra or missing register in the round loop.

// File: rtl/ced_pkg.sv
`timescale 1ns/1ps
// Shared types and pure round functions for the self-checking cipher.
// Assumes a 128-bit block split into four 32-bit lanes.
package ced_pkg;
    localparam int BLK_W  = 128;
    localparam int LANE_W = 32;
    localparam int NIB_W  = 4;
    localparam int ROT_A  = 5;
    localparam int ROT_B  = 11;
    localparam int ROT_C  = 7;
    localparam int ROT_D  = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ENC  = 2'd1,
        PH_DEC  = 2'd2
    } ced_phase_e;

    function automatic logic [NIB_W-1:0] sb_fwd(input logic [NIB_W-1:0] n);
        case (n)
            4'h0: return 4'hC;  4'h1: return 4'h5;  4'h2: return 4'h6;  4'h3: return 4'hB;
            4'h4: return 4'h9;  4'h5: return 4'h0;  4'h6: return 4'hA;  4'h7: return 4'hD;
            4'h8: return 4'h3;  4'h9: return 4'hE;  4'hA: return 4'hF;  4'hB: return 4'h8;
            4'hC: return 4'h4;  4'hD: return 4'h7;  4'hE: return 4'h1;  default: return 4'h2;
        endcase
    endfunction

    function automatic logic [NIB_W-1:0] sb_inv(input logic [NIB_W-1:0] n);
        case (n)
            4'h0: return 4'h5;  4'h1: return 4'hE;  4'h2: return 4'hF;  4'h3: return 4'h8;
            4'h4: return 4'hC;  4'h5: return 4'h1;  4'h6: return 4'h2;  4'h7: return 4'hD;
            4'h8: return 4'hB;  4'h9: return 4'h4;  4'hA: return 4'h6;  4'hB: return 4'h3;
            4'hC: return 4'h0;  4'hD: return 4'h7;  4'hE: return 4'h9;  default: return 4'hA;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] rotl(input logic [LANE_W-1:0] v, input int s);
        return (v << s) | (v >> (LANE_W - s));
    endfunction

    function automatic logic [BLK_W-1:0] mix_fwd(input logic [BLK_W-1:0] x);
        logic [LANE_W-1:0] a, b, c, d;
        {d, c, b, a} = x;
        a = a ^ rotl(d, ROT_A);
        b = b ^ rotl(a, ROT_B);
        c = c ^ rotl(b, ROT_C);
        d = d ^ rotl(c, ROT_D);
        return {d, c, b, a};
    endfunction

    function automatic logic [BLK_W-1:0] mix_inv(input logic [BLK_W-1:0] x);
        logic [LANE_W-1:0] a, b, c, d;
        {d, c, b, a} = x;
        d = d ^ rotl(c, ROT_D);
        c = c ^ rotl(b, ROT_C);
        b = b ^ rotl(a, ROT_B);
        a = a ^ rotl(d, ROT_A);
        return {d, c, b, a};
    endfunction
endpackage

// File: rtl/ced_round_unit.sv
`timescale 1ns/1ps
// One half-round of either direction, purely combinational.
// Forward: half 0 = key XOR + S-layer; half 1 = mix, or final key XOR on the edge round.
// Inverse: half 0 = unmix, or final key XOR on the edge round; half 1 = inverse S-layer + key XOR.
// Assumes W equals ced_pkg::BLK_W.
module ced_round_unit #(
    parameter int W = ced_pkg::BLK_W
) (
    input  logic [W-1:0] blk_in,
    input  logic [W-1:0] rkey,
    input  logic         go_inv,
    input  logic         second_half,
    input  logic         edge_rnd,
    output logic [W-1:0] blk_out
);
    import ced_pkg::*;
    localparam int NNIB = W / NIB_W;

    logic [W-1:0] keyed, sub_f, sub_i;

    assign keyed = blk_in ^ rkey;

    // Nibble substitution in both directions, one S-box pair per nibble.
    for (genvar g = 0; g < NNIB; g++) begin : g_nib
        assign sub_f[g*NIB_W +: NIB_W] = sb_fwd(keyed[g*NIB_W +: NIB_W]);
        assign sub_i[g*NIB_W +: NIB_W] = sb_inv(blk_in[g*NIB_W +: NIB_W]);
    end

    // Select the half-round result for the current direction and half.
    always_comb begin
        if (!go_inv) begin
            if (!second_half)  blk_out = sub_f;
            else if (edge_rnd) blk_out = keyed;
            else               blk_out = mix_fwd(blk_in);
        end else begin
            if (second_half)   blk_out = sub_i ^ rkey;
            else if (edge_rnd) blk_out = keyed;
            else               blk_out = mix_inv(blk_in);
        end
    end
endmodule

// File: rtl/ced_seq.sv
`timescale 1ns/1ps
// Phase and round sequencer: idle -> encrypt (ROUNDS x 2 cycles) -> decrypt
// (ROUNDS x 2 cycles) -> idle. Drives the key address; keys are read combinationally.
module ced_seq #(
    parameter int ROUNDS    = 32,
    parameter int KEY_WORDS = ROUNDS + 1,
    parameter int AW        = $clog2(KEY_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          idle,
    output logic          enc_on,
    output logic          dec_on,
    output logic          half,
    output logic          edge_rnd,
    output logic          last_enc,
    output logic          last_dec,
    output logic [AW-1:0] key_addr
);
    import ced_pkg::*;
    localparam int             RW   = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [RW-1:0]  RMAX = RW'(ROUNDS - 1);
    localparam logic [AW-1:0]  KLST = AW'(ROUNDS);

    ced_phase_e     phase;
    logic [RW-1:0]  rnd;

    assign idle   = (phase == PH_IDLE);
    assign enc_on = (phase == PH_ENC);
    assign dec_on = (phase == PH_DEC);

    // Edge round: last encryption round, or the first decryption round that undoes it.
    assign edge_rnd = enc_on ? (rnd == RMAX) : (rnd == '0);
    assign last_enc = enc_on && half && (rnd == RMAX);
    assign last_dec = dec_on && half && (rnd == RMAX);

    // Key address: forward order for encryption, reversed for decryption, extra word on the edge.
    always_comb begin
        key_addr = AW'(rnd);
        if (enc_on && half && edge_rnd)
            key_addr = KLST;
        else if (dec_on && !half && edge_rnd)
            key_addr = KLST;
        else if (dec_on)
            key_addr = AW'(ROUNDS - 1) - AW'(rnd);
    end

    // Advance half, round and phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            rnd   <= '0;
            half  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_ENC;
                        rnd   <= '0;
                        half  <= 1'b0;
                    end
                end
                PH_ENC, PH_DEC: begin
                    half <= ~half;
                    if (half) begin
                        if (rnd == RMAX) begin
                            rnd   <= '0;
                            phase <= (phase == PH_ENC) ? PH_DEC : PH_IDLE;
                        end else begin
                            rnd <= rnd + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    key_addr_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> key_addr < AW'(KEY_WORDS));

    // R4
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enc_on) |-> dec_on);
endmodule

// File: rtl/ced_lfsr.sv
`timescale 1ns/1ps
// Free-running Fibonacci LFSR supplying the substitute word released on a fault.
// Shifts left every cycle out of reset; the seed must be nonzero.
module ced_lfsr #(
    parameter int          W    = 128,
    parameter logic [W-1:0] SEED = {64'h0123456789ABCDEF, 64'hFEDCBA9876543210},
    parameter int          T0   = 127,
    parameter int          T1   = 125,
    parameter int          T2   = 100,
    parameter int          T3   = 98
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] lfsr
);
    // Shift in the tap parity each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= SEED;
        else        lfsr <= {lfsr[W-2:0], lfsr[T0] ^ lfsr[T1] ^ lfsr[T2] ^ lfsr[T3]};
    end

    // R6
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
endmodule

// File: rtl/ced_cipher_guard.sv
`timescale 1ns/1ps
// Self-checking cipher top. Encrypts, decrypts the result, compares with the held
// plaintext; releases ciphertext on match, LFSR word plus sticky error on mismatch.
// Assumes an external key memory with combinational read of ROUNDS+1 words.
module ced_cipher_guard #(
    parameter int           W         = 128,
    parameter int           ROUNDS    = 32,
    parameter int           KEY_WORDS = ROUNDS + 1,
    parameter int           AW        = $clog2(KEY_WORDS),
    parameter logic [W-1:0] SEED      = {64'h0123456789ABCDEF, 64'hFEDCBA9876543210}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  plaintext,
    input  logic [W-1:0]  inject_flip,
    output logic [AW-1:0] key_addr,
    input  logic [W-1:0]  key_rdata,
    output logic [W-1:0]  cipher_out,
    output logic          valid,
    output logic          error
);
    logic idle, enc_on, dec_on, half, edge_rnd, last_enc, last_dec;
    logic [W-1:0] st_q, pt_q, ct_q, rnd_y, lfsr_q, enc_next;
    logic accept, match;

    ced_seq #(.ROUNDS(ROUNDS), .KEY_WORDS(KEY_WORDS), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
        .enc_on(enc_on), .dec_on(dec_on), .half(half), .edge_rnd(edge_rnd),
        .last_enc(last_enc), .last_dec(last_dec), .key_addr(key_addr)
    );

    ced_round_unit #(.W(W)) u_round (
        .blk_in(st_q), .rkey(key_rdata), .go_inv(dec_on),
        .second_half(half), .edge_rnd(edge_rnd), .blk_out(rnd_y)
    );

    ced_lfsr #(.W(W), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .lfsr(lfsr_q)
    );

    assign accept   = start && idle;
    assign enc_next = rnd_y ^ inject_flip;
    assign match    = (rnd_y == pt_q);

    // State register with the 2:1 input mux; holds plaintext, ciphertext copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            pt_q <= '0;
            ct_q <= '0;
        end else if (accept) begin
            st_q <= plaintext;
            pt_q <= plaintext;
        end else if (enc_on) begin
            st_q <= enc_next;
            if (last_enc) ct_q <= enc_next;
        end else if (dec_on) begin
            st_q <= rnd_y;
        end
    end

    // Release stage: compare once decryption finishes, gate the output on the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cipher_out <= '0;
            valid      <= 1'b0;
            error      <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (accept) begin
                error <= 1'b0;
            end else if (last_dec) begin
                valid      <= 1'b1;
                error      <= !match;
                cipher_out <= match ? ct_q : lfsr_q;
            end
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> valid);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R2
    pt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(pt_q));
endmodule

// File: tb/ced_cipher_guard_test.sv
`timescale 1ns/1ps
module ced_cipher_guard_test;
    localparam int W  = 128;
    localparam int NR = 32;
    localparam int NK = NR + 1;
    localparam int AW = 6;
    localparam logic [W-1:0] SEED = {64'h0123456789ABCDEF, 64'hFEDCBA9876543210};
    localparam logic [3:0] SBT [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                        4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [W-1:0] plaintext = '0, inject = '0;
    logic [AW-1:0] key_addr;
    logic [W-1:0] key_rdata, cipher_out;
    logic valid, error;
    logic [W-1:0] kmem [NK];

    always #2 clk = ~clk;

    assign key_rdata = (key_addr < AW'(NK)) ? kmem[key_addr] : '0;

    ced_cipher_guard uut (
        .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
        .inject_flip(inject), .key_addr(key_addr), .key_rdata(key_rdata),
        .cipher_out(cipher_out), .valid(valid), .error(error)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] v, input int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    // Behavioural reference encryption (R3).
    function automatic logic [W-1:0] enc_ref(input logic [W-1:0] p);
        logic [W-1:0] x;
        logic [31:0] w [4];
        x = p;
        for (int r = 0; r < NR; r++) begin
            x ^= kmem[r];
            for (int n = 0; n < W/4; n++) x[4*n +: 4] = SBT[x[4*n +: 4]];
            if (r == NR - 1) begin
                x ^= kmem[NR];
            end else begin
                for (int j = 0; j < 4; j++) w[j] = x[32*j +: 32];
                w[0] ^= rl(w[3], 5);
                w[1] ^= rl(w[0], 11);
                w[2] ^= rl(w[1], 7);
                w[3] ^= rl(w[2], 3);
                x = {w[3], w[2], w[1], w[0]};
            end
        end
        return x;
    endfunction

    task automatic load_keys(input logic [31:0] s);
        for (int i = 0; i < NK; i++)
            kmem[i] = {s ^ 32'(i * 32'h9E3779B9), 32'(i * 7 + 1) ^ {s[15:0], s[31:16]},
                       ~32'(i) ^ s, 32'(i << 3) + s};
    endtask

    // Cycle-level reference model, updated on each rising edge.
    bit m_busy = 0, m_valid = 0, m_err = 0, m_fault = 0;
    int m_cnt = 0;
    logic [W-1:0] m_lfsr = SEED, m_out = '0, m_ct = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_lfsr = SEED; m_err = 0; m_valid = 0;
            m_out = '0; m_fault = 0;
        end else begin
            m_valid = 0;
            if (m_busy) begin
                if (m_cnt < 2*NR && inject != '0) m_fault = 1;
                if (m_cnt == 4*NR - 1) begin
                    m_busy = 0; m_valid = 1; m_err = m_fault;
                    m_out = m_fault ? m_lfsr : m_ct;
                end
                m_cnt++;
            end else if (start) begin
                m_busy = 1; m_cnt = 0; m_fault = 0; m_err = 0;
                m_ct = enc_ref(plaintext);
            end
            m_lfsr = {m_lfsr[W-2:0], m_lfsr[127] ^ m_lfsr[125] ^ m_lfsr[100] ^ m_lfsr[98]};
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4", W'(valid), W'(m_valid), "valid");
            chk("R6", W'(error), W'(m_err), "error");
            chk("R5", cipher_out, m_out, "cipher_out");
        end
    end

    task automatic do_start(input logic [W-1:0] p);
        @(negedge clk); start = 1'b1; plaintext = p;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!valid && n < 1000);
    endtask

    task automatic hit_step(input int k, input logic [W-1:0] mask);
        repeat (k) @(negedge clk);
        inject = mask;
        @(negedge clk);
        inject = '0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        logic [W-1:0] p1, p2, held;
        load_keys(32'hC0DE_1234);
        repeat (3) @(negedge clk);
        chk("R1", {valid, error}, '0, "flags in reset");
        chk("R1", cipher_out, '0, "output in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", cipher_out, '0, "output after reset");

        // Clean run: latency and ciphertext.
        p1 = {64'h0011223344556677, 64'h8899AABBCCDDEEFF};
        do_start(p1);
        wait_valid(lat);
        chk("R4", W'(lat), W'(4*NR), "latency");
        chk("R3", cipher_out, enc_ref(p1), "ciphertext");
        chk("R5", W'(error), '0, "clean error");

        // Start and plaintext changes while busy are ignored.
        p2 = {4{32'hDEADBEEF}};
        do_start(p2);
        repeat (20) @(negedge clk);
        start = 1'b1; plaintext = ~p2;
        @(negedge clk); start = 1'b0;
        repeat (70) @(negedge clk);
        plaintext = '1;
        wait_valid(lat);
        chk("R2", cipher_out, enc_ref(p2), "busy start ignored");

        // Fault on first encryption cycle.
        do_start(p1);
        hit_step(0, W'(1) << 5);
        wait_valid(lat);
        chk("R6", W'(error), W'(1), "fault at first step");
        chk("R6", cipher_out, m_out, "substitute word");
        held = cipher_out;
        repeat (6) @(negedge clk);
        chk("R7", W'(error), W'(1), "error sticky");
        chk("R7", cipher_out, held, "output held");

        // Fault aimed at decryption is ignored; start clears error.
        do_start(p2);
        chk("R7", W'(error), '0, "start clears error");
        hit_step(80, {W{1'b1}});
        wait_valid(lat);
        chk("R8", W'(error), '0, "decrypt-phase flip ignored");
        chk("R8", cipher_out, enc_ref(p2), "decrypt-phase output");

        // Fault on last encryption cycle.
        do_start('0);
        hit_step(2*NR - 1, W'(1) << 127);
        wait_valid(lat);
        chk("R8", W'(error), W'(1), "fault at last enc step");

        // New key set, all-ones block.
        load_keys(32'h5A5A_0F0F);
        do_start('1);
        wait_valid(lat);
        chk("R3", cipher_out, enc_ref('1), "second key set");
        chk("R5", W'(error), '0, "second key set error");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule